// File: doc/BRIEF.md
# Write-Only Two-Wire Command/Data Receiver

This block is the serial front door of a character display controller. It listens on a two-wire bus (SCL clock, SDA data) as a slave at one fixed 7-bit address, and it only ever accepts writes. The only thing it places on SDA is an acknowledge, which it gives by pulling the line low. Both bus lines are sampled by the system clock. Each line passes through a synchroniser and a three-sample vote before the logic looks for edges, start conditions and stop conditions.

Once the address matches, the byte stream is read as pairs of a control byte followed by a payload byte. The control byte carries a continuation flag and a register-select flag. When a control byte has the continuation flag cleared, every later byte up to the end of the transfer is a payload byte that uses that byte's register-select value.

Each payload byte appears for one cycle on a valid/ready output. A tag marks it as an instruction or as display RAM data. If the consumer is not ready when a payload byte completes, that byte is refused on the bus (no acknowledge) and an overflow flag is raised.

Top module: `cmd_link_rx`

## Requirements
- R1: A transfer begins only with a start condition: SDA falls while SCL is high. A stop condition is SDA rising while SCL is high, and it ends the transfer. Bytes clocked in with no start before them are never acknowledged. After reset the block drives nothing, and valid and overflow are low.
- R2: The first byte after a start is the address byte. Bits 7..1 hold the address and bit 0 holds the direction. The byte is acknowledged only when bits 7..1 equal 7'h3E and bit 0 is 0, so the byte value is 8'h7C.
- R3: The acknowledge drives SDA low from the falling SCL edge that ends bit 8 until the falling edge that ends the 9th clock. The drive is never active while the 8th bit is high. The drive changes only while SCL is low.
- R4: A control byte keeps the continuation flag in bit 7 and the register-select flag in bit 6. Bits 5..0 are ignored. With bit 7 = 1, exactly one payload byte follows, and the byte after it is again a control byte.
- R5: After a control byte with bit 7 = 0, every remaining byte until stop or start is a payload byte that carries that control byte's bit 6.
- R6: Each payload byte appears once as a one-cycle pulse on pay_valid_o, with the byte on pay_data_o. pay_ram_o = 1 marks display RAM data and 0 marks an instruction. Address and control bytes never appear on the payload output.
- R7: An address other than 7'h3E, or a direction bit of 1, is not acknowledged. Every later byte of that transfer is then neither acknowledged nor delivered, until the next start.
- R8: A repeated start at any point sends the parser back to the address phase.
- R9: A stop in the middle of a byte throws away the partial byte. The next transfer starts from an empty shifter, and a stop releases the SDA drive.
- R10: A pulse on SCL or SDA that lasts a single system clock is ignored. It does not add a bit, and it does not create a start or a stop.
- R11: If pay_ready_i is low in the cycle a payload byte completes, that byte is not acknowledged and not delivered, and overflow_o is set. The parser still moves on as if the byte had been taken. overflow_o clears at the next start condition. Control and address bytes are acknowledged whatever pay_ready_i is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired value) |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain acknowledge) |
| pay_ready_i | input | 1 | Consumer can take a payload byte this cycle |
| pay_valid_o | output | 1 | One-cycle payload strobe |
| pay_data_o | output | 8 | Payload byte |
| pay_ram_o | output | 1 | 1 = display RAM data, 0 = instruction |
| overflow_o | output | 1 | A payload byte was refused for lack of ready |

## Verification
A payload byte completing and the consumer dropping ready can fall in the same system cycle, and the block must then choose between delivering the byte and refusing it. The bench lowers pay_ready_i before the last bit of a payload byte and keeps it low through the cycle in which that byte completes. It then checks three things: the acknowledge slot shows SDA high, no payload strobe appears, and overflow_o is high. It also checks that the next byte, sent with ready high again, is still read as a payload of the same stream.

// File: rtl/cmdlink_pkg.sv
package cmdlink_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_ADDR,
    PS_CTRL,
    PS_ONE,
    PS_STREAM,
    PS_SKIP
  } parse_t;

  // majority of three samples
  function automatic logic vote3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  // address byte: bits 7..1 = address, bit 0 = direction (0 = write)
  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] own);
    return (b[7:1] == own) && !b[0];
  endfunction

  // control byte: bit 7 = continuation, bit 6 = register select
  function automatic logic ctrl_more(input logic [7:0] b);
    return b[7];
  endfunction

  function automatic logic ctrl_ram(input logic [7:0] b);
    return b[6];
  endfunction

endpackage

// File: rtl/cl_line_filter.sv
module cl_line_filter
  import cmdlink_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [2:0]             win_q;
  logic                   clean_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      win_q   <= '1;
      clean_q <= 1'b1;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], raw_i};
      win_q   <= {win_q[1:0], sync_q[SYNC_STAGES-1]};
      clean_q <= vote3(win_q);
    end
  end

  assign clean_o = clean_q;

  AST_VOTE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clean_q) |-> ($countones($past(win_q)) >= 2)); // R10
  AST_VOTE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clean_q) |-> ($countones($past(win_q)) <= 1)); // R10

endmodule

// File: rtl/cl_bus_events.sv
module cl_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_c,
  input  logic sda_c,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);

  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_c;
      sda_p <= sda_c;
    end
  end

  assign start_ev = scl_c && scl_p && sda_p && !sda_c;
  assign stop_ev  = scl_c && scl_p && !sda_p && sda_c;
  assign scl_rise = scl_c && !scl_p;
  assign scl_fall = !scl_c && scl_p;

endmodule

// File: rtl/cl_byte_engine.sv
module cl_byte_engine
  import cmdlink_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              scl_c,
  input  logic              sda_c,
  input  logic              ack_ok,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_q,
  output logic              sda_low
);

  localparam int CNT_W = $clog2(BYTE_W);

  logic              active;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic              ack_wait, ack_slot, ack_pend;
  logic              last_bit;

  assign last_bit = (cnt == CNT_W'(BYTE_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      cnt       <= '0;
      shreg     <= '0;
      byte_q    <= '0;
      byte_done <= 1'b0;
      ack_wait  <= 1'b0;
      ack_slot  <= 1'b0;
      ack_pend  <= 1'b0;
      sda_low   <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (start_ev) begin
        active   <= 1'b1;
        cnt      <= '0;
        ack_wait <= 1'b0;
        ack_slot <= 1'b0;
        sda_low  <= 1'b0;
      end else if (stop_ev) begin
        active   <= 1'b0;
        cnt      <= '0;
        ack_wait <= 1'b0;
        ack_slot <= 1'b0;
        sda_low  <= 1'b0;
      end else if (active) begin
        if (byte_done) ack_pend <= ack_ok;
        if (scl_rise && !ack_slot && !ack_wait) begin
          shreg <= {shreg[BYTE_W-2:0], sda_c};
          cnt   <= cnt + 1'b1;
          if (last_bit) begin
            byte_q    <= {shreg[BYTE_W-2:0], sda_c};
            byte_done <= 1'b1;
            ack_wait  <= 1'b1;
          end
        end
        if (scl_fall && ack_wait) begin
          ack_wait <= 1'b0;
          ack_slot <= 1'b1;
          sda_low  <= ack_pend;
        end else if (scl_fall && ack_slot) begin
          ack_slot <= 1'b0;
          sda_low  <= 1'b0;
        end
      end
    end
  end

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_low != $past(sda_low)) |-> !scl_c); // R3
  AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sda_low); // R1

endmodule

// File: rtl/cl_parser.sv
module cl_parser
  import cmdlink_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h3E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_q,
  input  logic              pay_ready,
  output logic              ack_ok,
  output logic              pay_valid,
  output logic [BYTE_W-1:0] pay_data,
  output logic              pay_ram,
  output logic              overflow
);

  parse_t state;
  logic   rs_q;
  logic   payload_ph;

  assign payload_ph = (state == PS_ONE) || (state == PS_STREAM);

  always_comb begin
    case (state)
      PS_ADDR:           ack_ok = addr_hit(byte_q, OWN_ADDR);
      PS_CTRL:           ack_ok = 1'b1;
      PS_ONE, PS_STREAM: ack_ok = pay_ready;
      default:           ack_ok = 1'b0;
    endcase
  end

  assign pay_valid = byte_done && payload_ph && pay_ready;
  assign pay_data  = byte_q;
  assign pay_ram   = rs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PS_IDLE;
      rs_q     <= 1'b0;
      overflow <= 1'b0;
    end else if (start_ev) begin
      state    <= PS_ADDR;
      overflow <= 1'b0;
    end else if (stop_ev) begin
      state <= PS_IDLE;
    end else if (byte_done) begin
      case (state)
        PS_ADDR: state <= addr_hit(byte_q, OWN_ADDR) ? PS_CTRL : PS_SKIP;
        PS_CTRL: begin
          rs_q  <= ctrl_ram(byte_q);
          state <= ctrl_more(byte_q) ? PS_ONE : PS_STREAM;
        end
        PS_ONE: begin
          if (!pay_ready) overflow <= 1'b1;
          state <= PS_CTRL;
        end
        PS_STREAM: if (!pay_ready) overflow <= 1'b1;
        default: state <= state;
      endcase
    end
  end

  AST_OVF_MEANS_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(byte_done && !ack_ok)); // R11
  AST_RS_HELD_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_STREAM && $past(state == PS_STREAM)) |-> $stable(rs_q)); // R5
  AST_SKIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state == PS_SKIP) && !$past(start_ev)) |->
      (state == PS_SKIP || state == PS_IDLE)); // R7

endmodule

// File: rtl/cmd_link_rx.sv
module cmd_link_rx
  import cmdlink_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR    = 7'h3E,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic              pay_ready_i,
  output logic              pay_valid_o,
  output logic [BYTE_W-1:0] pay_data_o,
  output logic              pay_ram_o,
  output logic              overflow_o
);

  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines, clean_lines;
  logic               scl_c, sda_c;
  logic               start_ev, stop_ev, scl_rise, scl_fall;
  logic               byte_done, ack_ok;
  logic [BYTE_W-1:0]  byte_q;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    cl_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw_i(raw_lines[g]), .clean_o(clean_lines[g])
    );
  end

  assign scl_c = clean_lines[1];
  assign sda_c = clean_lines[0];

  cl_bus_events u_ev (
    .clk(clk), .rst_n(rst_n), .scl_c(scl_c), .sda_c(sda_c),
    .start_ev(start_ev), .stop_ev(stop_ev), .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  cl_byte_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .scl_c(scl_c), .sda_c(sda_c),
    .ack_ok(ack_ok), .byte_done(byte_done), .byte_q(byte_q), .sda_low(sda_pull_o)
  );

  cl_parser #(.OWN_ADDR(OWN_ADDR)) u_par (
    .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .stop_ev(stop_ev),
    .byte_done(byte_done), .byte_q(byte_q), .pay_ready(pay_ready_i),
    .ack_ok(ack_ok), .pay_valid(pay_valid_o), .pay_data(pay_data_o),
    .pay_ram(pay_ram_o), .overflow(overflow_o)
  );

  AST_VALID_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid_o |-> pay_ready_i); // R11
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_pull_o); // R9
  AST_VALID_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid_o |-> byte_done); // R6

endmodule

// File: tb/cmd_link_rx_tb.sv
module cmd_link_rx_tb;

  localparam int Q = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, g_scl = 1'b0, g_sda = 1'b0;
  logic ready = 1'b1;
  logic drv, pv, pram, ovf;
  logic [7:0] pdata;
  logic scl_line, sda_line;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [8:0] expq[$];
  string      tagq[$];

  always #2 clk = ~clk;

  assign scl_line = m_scl ^ g_scl;
  assign sda_line = (m_sda ^ g_sda) & ~drv;

  cmd_link_rx u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .sda_pull_o(drv), .pay_ready_i(ready), .pay_valid_o(pv),
    .pay_data_o(pdata), .pay_ram_o(pram), .overflow_o(ovf)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_pay(input bit ram, input logic [7:0] d, input string req);
    expq.push_back({ram, d});
    tagq.push_back(req);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && pv) begin
      if (expq.size() == 0) begin
        check(1'b0, "R6", "unexpected payload", {pram, pdata}, 0);
      end else begin
        logic [8:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check({pram, pdata} == e, t, "payload", {pram, pdata}, e);
      end
    end
  end

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic bit_out(input bit b, input int glitch, output bit d);
    m_sda = b; tick(Q);
    m_scl = 1'b1; tick(Q);
    d = drv;
    if (glitch == 1) begin g_sda = 1'b1; tick(1); g_sda = 1'b0; tick(Q - 1); end
    else tick(Q);
    m_scl = 1'b0;
    if (glitch == 2) begin tick(Q / 2); g_scl = 1'b1; tick(1); g_scl = 1'b0; tick(Q - Q / 2 - 1); end
    else tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req,
                           input int gbit = -1, input int gkind = 0);
    bit d, a;
    for (int i = 7; i >= 0; i--) begin
      bit_out(b[i], (i == gbit) ? gkind : 0, d);
      if (i == 0) check(!d, "R3", "drive during bit 8 high", d, 0);
    end
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    a = (sda_line == 1'b0);
    tick(Q);
    m_scl = 1'b0; tick(Q);
    check(a == exp_ack, req, $sformatf("ack for byte %02h", b), a, exp_ack);
    check(!drv, "R3", "drive released after 9th clock", drv, 0);
  endtask

  task automatic queue_empty(input string req);
    tick(4 * Q);
    check(expq.size() == 0, req, "pending payloads", expq.size(), 0);
  endtask

  initial begin
    bit d;
    tick(5);
    rst_n = 1'b1;
    tick(10);
    check(!drv && !pv && !ovf, "R1", "reset outputs", {drv, pv, ovf}, 0);

    // R1: bytes with no start are ignored
    m_scl = 1'b0; tick(Q);
    send_byte(8'h7C, 1'b0, "R1");
    bus_stop(); tick(Q);

    // R2 R4 R6: paired control/payload, then a stream (R5)
    bus_start();
    send_byte(8'h7C, 1'b1, "R2");
    send_byte(8'h80, 1'b1, "R4");
    expect_pay(1'b0, 8'h38, "R4"); send_byte(8'h38, 1'b1, "R6");
    send_byte(8'hC0, 1'b1, "R4");
    expect_pay(1'b1, 8'h41, "R4"); send_byte(8'h41, 1'b1, "R6");
    send_byte(8'h7F, 1'b1, "R4");   // Co=0 RS=1, low bits ignored
    expect_pay(1'b1, 8'h42, "R5"); send_byte(8'h42, 1'b1, "R5");
    expect_pay(1'b1, 8'hC0, "R5"); send_byte(8'hC0, 1'b1, "R5");
    expect_pay(1'b1, 8'h80, "R5"); send_byte(8'h80, 1'b1, "R5");
    bus_stop();
    queue_empty("R5");

    // R5: instruction stream
    bus_start();
    send_byte(8'h7C, 1'b1, "R2");
    send_byte(8'h00, 1'b1, "R5");
    expect_pay(1'b0, 8'h39, "R5"); send_byte(8'h39, 1'b1, "R5");
    expect_pay(1'b0, 8'h14, "R5"); send_byte(8'h14, 1'b1, "R5");
    bus_stop();
    queue_empty("R6");

    // R7: wrong address, then read direction
    bus_start();
    send_byte(8'h7E, 1'b0, "R7");
    send_byte(8'h00, 1'b0, "R7");
    send_byte(8'h55, 1'b0, "R7");
    bus_stop();
    bus_start();
    send_byte(8'h7D, 1'b0, "R7");
    send_byte(8'h40, 1'b0, "R7");
    bus_stop();
    queue_empty("R7");

    // R8: repeated start returns to address phase
    bus_start();
    send_byte(8'h7C, 1'b1, "R8");
    send_byte(8'h40, 1'b1, "R8");
    expect_pay(1'b1, 8'h10, "R8"); send_byte(8'h10, 1'b1, "R8");
    bus_start();
    send_byte(8'h7C, 1'b1, "R8");
    send_byte(8'h80, 1'b1, "R8");
    expect_pay(1'b0, 8'h20, "R8"); send_byte(8'h20, 1'b1, "R8");
    bus_stop();
    queue_empty("R8");

    // R9: stop inside a byte discards it
    bus_start();
    send_byte(8'h7C, 1'b1, "R9");
    send_byte(8'h00, 1'b1, "R9");
    bit_out(1'b1, 0, d); bit_out(1'b0, 0, d); bit_out(1'b1, 0, d);
    bus_stop();
    bus_start();
    send_byte(8'h7C, 1'b1, "R9");
    send_byte(8'hC0, 1'b1, "R9");
    expect_pay(1'b1, 8'h33, "R9"); send_byte(8'h33, 1'b1, "R9");
    bus_stop();
    queue_empty("R9");

    // R10: single-cycle glitches on SDA (SCL high) and SCL (SCL low)
    bus_start();
    send_byte(8'h7C, 1'b1, "R10");
    send_byte(8'h40, 1'b1, "R10", 4, 1);
    expect_pay(1'b1, 8'h5A, "R10"); send_byte(8'h5A, 1'b1, "R10", 3, 1);
    expect_pay(1'b1, 8'hA5, "R10"); send_byte(8'hA5, 1'b1, "R10", 5, 2);
    bus_stop();
    queue_empty("R10");

    // R11: consumer not ready at payload completion
    bus_start();
    check(!ovf, "R11", "overflow clear at start", ovf, 0);
    ready = 1'b0;
    send_byte(8'h7C, 1'b1, "R11");
    send_byte(8'h40, 1'b1, "R11");
    send_byte(8'h66, 1'b0, "R11");
    check(ovf, "R11", "overflow after refusal", ovf, 1);
    ready = 1'b1;
    expect_pay(1'b1, 8'h67, "R11"); send_byte(8'h67, 1'b1, "R11");
    bus_stop();
    queue_empty("R11");
    check(ovf, "R11", "overflow held after stop", ovf, 1);
    bus_start();
    check(!ovf, "R11", "overflow cleared by start", ovf, 0);
    bus_stop();

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule